// File: doc/BRIEF.md
# CPU/GPU Link Bandwidth Splitter

This block sits in each router of a heterogeneous many-core network and decides how the router's outgoing link lanes are divided between traffic from the CPU cores and traffic from the GPU compute units. Every cycle it counts the occupied slots in the CPU input-buffer pool and in the GPU input-buffer pool. It compares each count against a small per-type fraction of that pool's size. It then walks a fixed priority chain that yields one of five lane splits, all in quarter steps.

The chain is deliberately lopsided. The GPU bound is tighter than the CPU bound, and the GPU bound is tested first. A lightly loaded GPU pool therefore hands the CPU the larger share, and a flood of GPU requests cannot push CPU traffic off the link.

The result is registered. It is presented as two lane counts and a 3-bit code that the reservation packet carries, with a one-cycle strobe that asks for that packet to be sent. The launch input gates each decision. When launch is low, or both pools are empty, the previous split is kept and no request is made.

Top module: `hbw_split_alloc`

## Requirements
- R1: When the GPU pool count is zero and the CPU pool count is nonzero, the next split is code 0: CPU gets all LANES lanes and GPU gets 0.
- R2: Otherwise, when the CPU pool count is zero and the GPU pool count is nonzero, the next split is code 1: GPU gets all LANES lanes and CPU gets 0.
- R3: Otherwise, when the GPU count is below the GPU bound, the next split is code 2: CPU gets 3*LANES/4 and GPU gets LANES/4. This test takes precedence over the CPU-bound test.
- R4: Otherwise, when the CPU count is below the CPU bound, the next split is code 3: GPU gets 3*LANES/4 and CPU gets LANES/4.
- R5: In every remaining case with both pools nonzero, the next split is code 4: each type gets LANES/2.
- R6: A count is below its bound exactly when count*100 < PCT*SLOTS, using integer arithmetic with no rounding. With the defaults, this means a CPU count of at most 2 of 16 slots (16 %) and a GPU count of at most 1 of 32 slots (6 %).
- R7: A pool count is the number of set occupied flags in that pool, whatever their bit positions.
- R8: When launch_i is low, or both pools are empty, the lanes and the code keep their previous values and resv_req_o is low in the next cycle.
- R9: A decision is taken at each rising clock edge where launch_i is high and at least one pool is nonzero. The lanes, the code and resv_req_o = 1 all appear right after that edge. The strobe stays high for as long as such edges continue.
- R10: During reset, the outputs are code 4, LANES/2 lanes for each type, and resv_req_o low.
- R11: cpu_lanes_o + gpu_lanes_o always equals LANES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_occ_i | input | CPU_SLOTS | One occupied flag per CPU buffer slot |
| gpu_occ_i | input | GPU_SLOTS | One occupied flag per GPU buffer slot |
| launch_i | input | 1 | Permits a new allocation decision this cycle |
| cpu_lanes_o | output | $clog2(LANES+1) | Lanes granted to CPU traffic |
| gpu_lanes_o | output | $clog2(LANES+1) | Lanes granted to GPU traffic |
| alloc_code_o | output | 3 | Split code carried in the reservation packet (0..4) |
| resv_req_o | output | 1 | Request to send a reservation packet with the new split |

## Verification
Two things can coincide in a single cycle: a fresh decision being taken, and the hold path that keeps the old split. The bench provokes this by dropping launch_i, or by emptying both pools, in the cycle right after a decision with a different code. The outputs must then stay at the earlier split with the strobe low, not pick up the new counts.

A second collision happens at the threshold edges. A count sits exactly on or just past a bound while the other pool is also light, so the GPU-first precedence decides the case. A behavioural reference model in the bench checks every one of these cycles.

// File: rtl/hbw_pkg.sv
// Shared types for the CPU/GPU link bandwidth splitter.
// Assumes: codes 0..4 are decoded by the reservation packet builder.
package hbw_pkg;
    typedef enum logic [2:0] {
        ALC_CPU_ALL = 3'd0,
        ALC_GPU_ALL = 3'd1,
        ALC_CPU_MAJ = 3'd2,
        ALC_GPU_MAJ = 3'd3,
        ALC_EVEN    = 3'd4
    } alloc_e;
endpackage

// File: rtl/hbw_occ_count.sv
// Counts set flags in one buffer pool.
// Assumes: flags are level signals, one per slot; result fits CW bits.
module hbw_occ_count #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  flags_i,
    output logic [CW-1:0] count_o
);
    // population count of the occupied flags
    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + CW'(flags_i[i]);
        end
    end
endmodule

// File: rtl/hbw_bound_cmp.sv
// Tests whether a pool count is below PCT percent of SLOTS without a divider.
// Assumes: CW covers 0..SLOTS; PCT*SLOTS*100 fits in 32 bits.
module hbw_bound_cmp #(
    parameter int SLOTS = 16,
    parameter int PCT   = 16,
    parameter int CW    = $clog2(SLOTS + 1)
) (
    input  logic [CW-1:0] count_i,
    output logic          below_o
);
    localparam int unsigned LIMIT = PCT * SLOTS;

    // strict compare of scaled count against the percent product
    always_comb begin
        below_o = (32'(count_i) * 32'd100) < LIMIT;
    end
endmodule

// File: rtl/hbw_split_chain.sv
// Fixed priority chain choosing one of five splits from pool state.
// Assumes: called only when at least one pool is nonzero.
module hbw_split_chain
    import hbw_pkg::*;
(
    input  logic   cpu_any_i,
    input  logic   gpu_any_i,
    input  logic   cpu_low_i,
    input  logic   gpu_low_i,
    output alloc_e code_o
);
    // GPU-bound test precedes CPU-bound test so CPU keeps the larger share
    always_comb begin
        if (!gpu_any_i && cpu_any_i)      code_o = ALC_CPU_ALL;
        else if (!cpu_any_i && gpu_any_i) code_o = ALC_GPU_ALL;
        else if (gpu_low_i)               code_o = ALC_CPU_MAJ;
        else if (cpu_low_i)               code_o = ALC_GPU_MAJ;
        else                              code_o = ALC_EVEN;
    end
endmodule

// File: rtl/hbw_split_alloc.sv
// Per-router lane splitter between CPU and GPU traffic.
// Counts both buffer pools, runs the priority chain and registers the
// resulting lane split, the packet code and a reservation strobe.
// Assumes: LANES divisible by 4; inputs synchronous to clk.
module hbw_split_alloc
    import hbw_pkg::*;
#(
    parameter int CPU_SLOTS = 16,
    parameter int GPU_SLOTS = 32,
    parameter int CPU_PCT   = 16,
    parameter int GPU_PCT   = 6,
    parameter int LANES     = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CPU_SLOTS-1:0]         cpu_occ_i,
    input  logic [GPU_SLOTS-1:0]         gpu_occ_i,
    input  logic                         launch_i,
    output logic [$clog2(LANES+1)-1:0]   cpu_lanes_o,
    output logic [$clog2(LANES+1)-1:0]   gpu_lanes_o,
    output logic [2:0]                   alloc_code_o,
    output logic                         resv_req_o
);
    localparam int CCW = $clog2(CPU_SLOTS + 1);
    localparam int GCW = $clog2(GPU_SLOTS + 1);
    localparam int LW  = $clog2(LANES + 1);
    localparam logic [LW-1:0] L_ALL  = LW'(LANES);
    localparam logic [LW-1:0] L_MAJ  = LW'((3 * LANES) / 4);
    localparam logic [LW-1:0] L_HALF = LW'(LANES / 2);
    localparam logic [LW-1:0] L_MIN  = LW'(LANES / 4);

    logic [CCW-1:0] cpu_cnt;
    logic [GCW-1:0] gpu_cnt;
    logic           cpu_low, gpu_low, cpu_any, gpu_any, decide;
    alloc_e         next_code, code_q;
    logic [LW-1:0]  next_cpu, next_gpu;

    hbw_occ_count #(.N(CPU_SLOTS), .CW(CCW)) cpu_cnt_i (.flags_i(cpu_occ_i), .count_o(cpu_cnt));
    hbw_occ_count #(.N(GPU_SLOTS), .CW(GCW)) gpu_cnt_i (.flags_i(gpu_occ_i), .count_o(gpu_cnt));

    hbw_bound_cmp #(.SLOTS(CPU_SLOTS), .PCT(CPU_PCT), .CW(CCW)) cpu_cmp_i (.count_i(cpu_cnt), .below_o(cpu_low));
    hbw_bound_cmp #(.SLOTS(GPU_SLOTS), .PCT(GPU_PCT), .CW(GCW)) gpu_cmp_i (.count_i(gpu_cnt), .below_o(gpu_low));

    // nonzero detection and decision enable
    always_comb begin
        cpu_any = (cpu_cnt != '0);
        gpu_any = (gpu_cnt != '0);
        decide  = launch_i && (cpu_any || gpu_any);
    end

    hbw_split_chain chain_i (
        .cpu_any_i (cpu_any),
        .gpu_any_i (gpu_any),
        .cpu_low_i (cpu_low),
        .gpu_low_i (gpu_low),
        .code_o    (next_code)
    );

    // map the chosen code to lane counts
    always_comb begin
        unique case (next_code)
            ALC_CPU_ALL: begin next_cpu = L_ALL;       next_gpu = '0;          end
            ALC_GPU_ALL: begin next_cpu = '0;          next_gpu = L_ALL;       end
            ALC_CPU_MAJ: begin next_cpu = L_MAJ;       next_gpu = L_MIN;       end
            ALC_GPU_MAJ: begin next_cpu = L_MIN;       next_gpu = L_MAJ;       end
            default:     begin next_cpu = L_HALF;      next_gpu = L_HALF;      end
        endcase
    end

    // register a decision when permitted, otherwise hold the split
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q      <= ALC_EVEN;
            cpu_lanes_o <= L_HALF;
            gpu_lanes_o <= L_HALF;
            resv_req_o  <= 1'b0;
        end else if (decide) begin
            code_q      <= next_code;
            cpu_lanes_o <= next_cpu;
            gpu_lanes_o <= next_gpu;
            resv_req_o  <= 1'b1;
        end else begin
            resv_req_o  <= 1'b0;
        end
    end

    // present the registered code as a plain vector
    always_comb alloc_code_o = code_q;
endmodule

// File: rtl/hbw_split_alloc_chk.sv
// Property checker for hbw_split_alloc, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module hbw_split_alloc_chk #(
    parameter int CPU_SLOTS = 16,
    parameter int GPU_SLOTS = 32,
    parameter int LANES     = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [CPU_SLOTS-1:0]       cpu_occ_i,
    input logic [GPU_SLOTS-1:0]       gpu_occ_i,
    input logic                       launch_i,
    input logic [$clog2(LANES+1)-1:0] cpu_lanes_o,
    input logic [$clog2(LANES+1)-1:0] gpu_lanes_o,
    input logic [2:0]                 alloc_code_o,
    input logic                       resv_req_o
);
    logic past_ok;

    // marks that one clock after reset release has been seen
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_cpu_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(launch_i && gpu_occ_i == '0 && cpu_occ_i != '0)
        |-> alloc_code_o == 3'd0 && gpu_lanes_o == '0);

    p_gpu_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(launch_i && cpu_occ_i == '0 && gpu_occ_i != '0)
        |-> alloc_code_o == 3'd1 && cpu_lanes_o == '0);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !resv_req_o |-> $stable(alloc_code_o) && $stable(cpu_lanes_o));

    p_no_req_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!launch_i || (cpu_occ_i == '0 && gpu_occ_i == '0))
        |-> !resv_req_o);

    p_req_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(launch_i && (cpu_occ_i != '0 || gpu_occ_i != '0))
        |-> resv_req_o);

    p_lane_sum_r11: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cpu_lanes_o) + 32'(gpu_lanes_o) == LANES);

    p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_code_o <= 3'd4);
endmodule

bind hbw_split_alloc hbw_split_alloc_chk #(
    .CPU_SLOTS (CPU_SLOTS),
    .GPU_SLOTS (GPU_SLOTS),
    .LANES     (LANES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_occ_i    (cpu_occ_i),
    .gpu_occ_i    (gpu_occ_i),
    .launch_i     (launch_i),
    .cpu_lanes_o  (cpu_lanes_o),
    .gpu_lanes_o  (gpu_lanes_o),
    .alloc_code_o (alloc_code_o),
    .resv_req_o   (resv_req_o)
);

// File: tb/hbw_split_alloc_tb_top.sv
// Bench for hbw_split_alloc: behavioural reference model compared every clock.
module hbw_split_alloc_tb_top;
    localparam int CS = 16;
    localparam int GS = 32;
    localparam int CP = 16;
    localparam int GP = 6;
    localparam int LN = 64;
    localparam int LW = $clog2(LN + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CS-1:0] cpu_v = '0;
    logic [GS-1:0] gpu_v = '0;
    logic          launch = 1'b0;
    logic [LW-1:0] cpu_l, gpu_l;
    logic [2:0]    code;
    logic          req;

    int    checks = 0;
    int    errors = 0;
    bit    running = 1'b0;
    string tag = "R10";

    int e_code = 4, e_cpu = LN / 2, e_gpu = LN / 2;
    bit e_req = 1'b0;

    always #2 clk = ~clk;

    hbw_split_alloc #(
        .CPU_SLOTS (CS), .GPU_SLOTS (GS), .CPU_PCT (CP), .GPU_PCT (GP), .LANES (LN)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cpu_occ_i (cpu_v), .gpu_occ_i (gpu_v),
        .launch_i (launch), .cpu_lanes_o (cpu_l), .gpu_lanes_o (gpu_l),
        .alloc_code_o (code), .resv_req_o (req)
    );

    // reference model built from the requirement text
    always @(posedge clk) begin
        int c, g, k;
        c = $countones(cpu_v);
        g = $countones(gpu_v);
        if (!rst_n) begin
            k = 4; e_req <= 1'b0;
        end else if (launch && (c + g) > 0) begin
            if (g == 0)                k = 0;
            else if (c == 0)           k = 1;
            else if (g * 100 < GP * GS) k = 2;
            else if (c * 100 < CP * CS) k = 3;
            else                       k = 4;
            e_req <= 1'b1;
        end else begin
            k = -1; e_req <= 1'b0;
        end
        if (k >= 0) begin
            e_code <= k;
            case (k)
                0: begin e_cpu <= LN;         e_gpu <= 0;          end
                1: begin e_cpu <= 0;          e_gpu <= LN;         end
                2: begin e_cpu <= 3 * LN / 4; e_gpu <= LN / 4;     end
                3: begin e_cpu <= LN / 4;     e_gpu <= 3 * LN / 4; end
                default: begin e_cpu <= LN / 2; e_gpu <= LN / 2;   end
            endcase
        end
    end

    // compare outputs with the model midway between edges
    always @(negedge clk) begin
        if (running) begin
            checks++;
            if (int'(code) != e_code || int'(cpu_l) != e_cpu || int'(gpu_l) != e_gpu || req != e_req) begin
                errors++;
                $display("FAIL %s: got code=%0d cpu=%0d gpu=%0d req=%0b exp code=%0d cpu=%0d gpu=%0d req=%0b",
                         tag, code, cpu_l, gpu_l, req, e_code, e_cpu, e_gpu, e_req);
            end
            checks++;
            if (int'(cpu_l) + int'(gpu_l) != LN) begin
                errors++;
                $display("FAIL R11: got sum=%0d exp %0d", int'(cpu_l) + int'(gpu_l), LN);
            end
        end
    end

    function automatic logic [CS-1:0] fill_c(int n, int base);
        logic [CS-1:0] v = '0;
        for (int i = 0; i < n; i++) v[(base + i) % CS] = 1'b1;
        return v;
    endfunction

    function automatic logic [GS-1:0] fill_g(int n, int base);
        logic [GS-1:0] v = '0;
        for (int i = 0; i < n; i++) v[(base + i) % GS] = 1'b1;
        return v;
    endfunction

    task automatic step(string t, int c, int g, bit ln, int base, int cyc);
        @(negedge clk);
        tag = t;
        cpu_v = fill_c(c, base);
        gpu_v = fill_g(g, base);
        launch = ln;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic run_stim();
        logic [31:0] lf = 32'h1ACE_5EED;
        running = 1'b1;
        repeat (3) @(negedge clk);          // R10 reset values
        rst_n = 1'b1;
        step("R1", 5, 0, 1'b1, 0, 3);
        step("R2", 0, 7, 1'b1, 0, 3);
        step("R3", 10, 1, 1'b1, 0, 3);
        step("R4", 2, 20, 1'b1, 0, 3);
        step("R5", 3, 2, 1'b1, 0, 3);
        step("R6", 2, 2, 1'b1, 0, 2);       // CPU on bound side -> code 3
        step("R6", 3, 1, 1'b1, 0, 2);       // GPU at 1 -> code 2
        step("R6", 3, 2, 1'b1, 0, 2);       // both past bound -> code 4
        step("R7", 3, 1, 1'b1, 13, 2);      // same counts, wrapped positions
        step("R7", 2, 30, 1'b1, 29, 2);
        step("R8", 0, 9, 1'b0, 0, 3);       // launch low: hold code 3
        step("R8", 0, 0, 1'b1, 0, 3);       // empty pools: hold
        step("R9", 4, 0, 1'b1, 0, 1);       // decision then immediate hold
        step("R8", 0, 12, 1'b0, 0, 2);
        step("R10", 0, 12, 1'b1, 0, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step("R9", int'(lf[4:0]) % (CS + 1), int'(lf[13:8]) % (GS + 1),
                 lf[20] | lf[22], int'(lf[27:24]), 1);
        end
        running = 1'b0;
    endtask

    initial begin
        fork
            run_stim();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule